// File: doc/BRIEF.md
# Byte-Wide Crossbar Switch Fabric

This block connects N source ports to M sink ports over byte-wide data paths. A source opens a connection with a four-byte header: the first byte names the sink it wants and the next three bytes are zero. The fabric consumes the header and does not forward it. After the header, the source streams payload bytes. Each byte is copied to the chosen sink one clock after the fabric accepts it. The connection stays open until the sink sends a one-cycle done pulse. The source then returns to the header phase and may address any sink.

Each data interface works like a valid/ready stream with a coarse ready:
- The `*_we` strobe marks a valid byte.
- `src_hold` is the inverse of ready. A source samples it only at a four-byte burst boundary, and once a burst has begun the fabric takes all four bytes.
- On the sink side, `dst_full` is back-pressure with the same burst granularity. The fabric does not gate bytes on it. It passes it back to the connected source as `src_hold`.

When several waiting sources ask for the same free sink, a round-robin arbiter picks one of them. A header that names a sink number outside the fabric makes the source's following bytes disappear until the source leaves a gap at a burst boundary. The whole fabric runs on one clock.

Top module: `xbar_fabric`

## Requirements
- R1: While reset is held and in the first cycle after it, every `src_hold` and every `dst_we` is 0, and no connection exists.
- R2: The first byte of a source's header is the target sink number, and three more bytes follow. None of these four bytes appears on any `dst_we`/`dst_data`. Header bytes are taken with `src_hold` low.
- R3: If the addressed sink is free, `src_hold` goes high for one cycle after the last header byte and then low. Each payload byte accepted at a clock edge appears on the sink's `dst_data` with `dst_we` high in the following cycle, in order and unchanged.
- R4: While the addressed sink is owned by another source, the waiting source sees `src_hold` high, and none of its bytes reach any sink.
- R5: Arbitration among waiting sources for one free sink is round-robin, per sink:
  - The search starts at the source numbered one above the last winner for that sink, and starts at source 0 after reset.
  - The search wraps around, and exactly one source wins.
- R6: While a source is connected, its `src_hold` equals the `dst_full` of its sink in the same cycle. A burst already under way is forwarded whole even if `dst_full` rises in the middle of it.
- R7: A `dst_done` pulse on a sink ends the connection with that sink:
  - The source returns to the header phase.
  - The sink becomes free and can be granted one cycle after the pulse.
- R8: A header whose address byte is M or more sends nothing to any sink, and the bytes that follow are dropped with `src_hold` low. A cycle without `src_we` at a four-byte boundary returns the source to the header phase.
- R9: A source is connected to at most one sink at a time. Different source/sink pairs carry their streams in the same cycles without affecting each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_we | input | N | Per-source byte valid strobe |
| src_data | input | N*DW | Per-source byte; source i uses bits [i*DW +: DW] |
| src_hold | output | N | Per-source stop request, honoured at burst boundaries |
| dst_we | output | M | Per-sink byte valid strobe |
| dst_data | output | M*DW | Per-sink byte; sink j uses bits [j*DW +: DW] |
| dst_full | input | M | Per-sink back-pressure, sampled at burst boundaries |
| dst_done | input | M | Per-sink one-cycle pulse that ends the connection |

## Verification
The hardest case to reach from the ports is round-robin rotation. Several headers must finish in the same cycle on a sink whose pointer is not at zero. Otherwise the arbiter behaves like a fixed-priority encoder.

The bench sets this up in three steps:
1. It connects a single high-numbered source to the sink and releases it, which moves that sink's pointer.
2. It launches the headers of three other sources in lockstep.
3. It releases each winner with a done pulse, predicting every grant with a bench function.

A second hard case is `dst_full` rising halfway through a burst. The bench drives the flag between payload bytes.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  typedef enum logic [1:0] {
    PH_HDR  = 2'd0,
    PH_WAIT = 2'd1,
    PH_LINK = 2'd2,
    PH_DROP = 2'd3
  } phase_e;
endpackage

// File: rtl/xbar_rr_arb.sv
module xbar_rr_arb #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         enable,
  output logic [N-1:0] gnt,
  output logic [((N > 1) ? $clog2(N) : 1)-1:0] win
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] ptr;

  // search from ptr upward with wrap, first requester wins
  always_comb begin
    gnt = '0;
    win = '0;
    for (int k = 0; k < N; k++) begin
      if (enable && gnt == '0 && req[(int'(ptr) + k) % N]) begin
        gnt[(int'(ptr) + k) % N] = 1'b1;
        win = IW'((int'(ptr) + k) % N);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (|gnt) begin
      ptr <= (win == IW'(N - 1)) ? '0 : win + 1'b1;
    end
  end

  // R5
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
endmodule

// File: rtl/xbar_in_ctrl.sv
module xbar_in_ctrl
  import xbar_pkg::*;
#(
  parameter int M  = 4,
  parameter int DW = 8,
  parameter int TW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] data,
  input  logic          grant,
  input  logic          link_done,
  input  logic          tgt_full,
  output logic          req,
  output logic [TW-1:0] tgt,
  output logic          linked,
  output logic          hold
);
  localparam logic [7:0] M_B = 8'(M);

  phase_e     phase;
  logic [1:0] cnt;
  logic [7:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= PH_HDR;
      cnt    <= '0;
      addr_q <= '0;
    end else begin
      unique case (phase)
        PH_HDR: if (we) begin
          cnt <= cnt + 2'd1;
          if (cnt == 2'd0) addr_q <= data[7:0];
          if (cnt == 2'd3) phase <= (addr_q < M_B) ? PH_WAIT : PH_DROP;
        end
        PH_WAIT: if (grant) begin
          phase <= PH_LINK;
          cnt   <= '0;
        end
        PH_LINK: begin
          if (link_done) begin
            phase <= PH_HDR;
            cnt   <= '0;
          end else if (we) begin
            cnt <= cnt + 2'd1;
          end
        end
        PH_DROP: begin
          if (we) cnt <= cnt + 2'd1;
          else if (cnt == 2'd0) phase <= PH_HDR;
        end
        default: phase <= PH_HDR;
      endcase
    end
  end

  assign req    = (phase == PH_WAIT);
  assign linked = (phase == PH_LINK);
  assign tgt    = addr_q[TW-1:0];
  assign hold   = (phase == PH_WAIT) || ((phase == PH_LINK) && tgt_full);

  // R4
  grant_in_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (phase == PH_WAIT));
  // R7
  done_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_done |=> (phase == PH_HDR));
endmodule

// File: rtl/xbar_fabric.sv
module xbar_fabric #(
  parameter int N  = 4,
  parameter int M  = 4,
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    src_we,
  input  logic [N*DW-1:0] src_data,
  output logic [N-1:0]    src_hold,
  output logic [M-1:0]    dst_we,
  output logic [M*DW-1:0] dst_data,
  input  logic [M-1:0]    dst_full,
  input  logic [M-1:0]    dst_done
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam int TW = (M > 1) ? $clog2(M) : 1;

  logic [N-1:0]  req, linked, grant, link_done;
  logic [TW-1:0] tgt      [N];
  logic [M-1:0]  owned_by [N];
  logic [N-1:0]  gnt_m    [M];
  logic [M-1:0]  own_vld;
  logic [IW-1:0] own_id   [M];

  // cross-reference grants and done pulses per source
  always_comb begin
    for (int i = 0; i < N; i++) begin
      grant[i]     = 1'b0;
      link_done[i] = 1'b0;
      for (int j = 0; j < M; j++) begin
        owned_by[i][j] = own_vld[j] && (own_id[j] == IW'(i));
        grant[i]       = grant[i] | gnt_m[j][i];
        link_done[i]   = link_done[i] | (owned_by[i][j] && dst_done[j]);
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_src
    xbar_in_ctrl #(.M(M), .DW(DW), .TW(TW)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (src_we[i]),
      .data      (src_data[i*DW +: DW]),
      .grant     (grant[i]),
      .link_done (link_done[i]),
      .tgt_full  (dst_full[tgt[i]]),
      .req       (req[i]),
      .tgt       (tgt[i]),
      .linked    (linked[i]),
      .hold      (src_hold[i])
    );

    // R9
    one_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(owned_by[i]));
    // R9
    link_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      linked[i] == (|owned_by[i]));
  end

  for (genvar j = 0; j < M; j++) begin : g_dst
    logic [N-1:0]  rq;
    logic [IW-1:0] win;
    logic          ov_q, we_q;
    logic [IW-1:0] oid_q;
    logic [DW-1:0] dat_q;

    always_comb begin
      for (int i = 0; i < N; i++) rq[i] = req[i] && (tgt[i] == TW'(j));
    end

    xbar_rr_arb #(.N(N)) u_arb (
      .clk    (clk),
      .rst_n  (rst_n),
      .req    (rq),
      .enable (!ov_q && !dst_done[j]),
      .gnt    (gnt_m[j]),
      .win    (win)
    );

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ov_q  <= 1'b0;
        oid_q <= '0;
        we_q  <= 1'b0;
        dat_q <= '0;
      end else begin
        if (ov_q && dst_done[j]) ov_q <= 1'b0;
        else if (|gnt_m[j]) begin
          ov_q  <= 1'b1;
          oid_q <= win;
        end
        we_q  <= ov_q && src_we[oid_q];
        dat_q <= src_data[oid_q*DW +: DW];
      end
    end

    assign own_vld[j]            = ov_q;
    assign own_id[j]             = oid_q;
    assign dst_we[j]             = we_q;
    assign dst_data[j*DW +: DW]  = dat_q;
  end
endmodule

// File: tb/xbar_fabric_tb.sv
`timescale 1ns/1ps
module xbar_fabric_tb;
  localparam int N = 4, M = 4, DW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [N-1:0]    src_we = '0;
  logic [N*DW-1:0] src_data = '0;
  logic [N-1:0]    src_hold;
  logic [M-1:0]    dst_we;
  logic [M*DW-1:0] dst_data;
  logic [M-1:0]    dst_full = '0, dst_done = '0;

  xbar_fabric #(.N(N), .M(M), .DW(DW)) u_dut (.*);

  int    errors = 0, checks = 0;
  string ptag = "R2";
  logic [7:0] exp_q [M][$];

  task automatic check(bit ok, string tag, int act, int exp, string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int rr_pick(int ptr, logic [N-1:0] m);
    for (int k = 0; k < N; k++) if (m[(ptr + k) % N]) return (ptr + k) % N;
    return -1;
  endfunction

  // scoreboard: every sink byte must match the next expected byte
  always @(negedge clk) begin
    if (rst_n) begin
      for (int j = 0; j < M; j++) begin
        if (dst_we[j]) begin
          if (exp_q[j].size() == 0)
            check(1'b0, ptag, int'(dst_data[j*DW +: DW]), -1, "unexpected sink byte");
          else begin
            automatic logic [7:0] e = exp_q[j].pop_front();
            check(dst_data[j*DW +: DW] == e, "R3", int'(dst_data[j*DW +: DW]), int'(e),
                  "forwarded byte");
          end
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic send_word(int i, logic [31:0] w);
    for (int b = 0; b < 4; b++) begin
      src_we[i] = 1'b1;
      src_data[i*DW +: DW] = w[8*b +: 8];
      tick();
    end
    src_we[i] = 1'b0;
  endtask

  task automatic send_hdr_mask(logic [N-1:0] m, logic [7:0] a);
    for (int b = 0; b < 4; b++) begin
      for (int i = 0; i < N; i++) if (m[i]) begin
        src_we[i] = 1'b1;
        src_data[i*DW +: DW] = (b == 0) ? a : 8'h00;
      end
      tick();
    end
    src_we = src_we & ~m;
  endtask

  task automatic send_payload(int i, int j, int nb);
    for (int k = 0; k < nb; k++) begin
      automatic logic [31:0] w = $urandom;
      for (int b = 0; b < 4; b++) exp_q[j].push_back(w[8*b +: 8]);
      send_word(i, w);
    end
  endtask

  task automatic wait_unhold(int i, output int cyc);
    cyc = 0;
    while (cyc < 30) begin
      @(negedge clk);
      if (!src_hold[i]) break;
      cyc++;
    end
    @(posedge clk); #1;
  endtask

  task automatic pulse_done(int j);
    dst_done[j] = 1'b1;
    tick();
    dst_done[j] = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int c, ptr;
    logic [N-1:0] pend;
    void'($urandom(32'd1357));
    repeat (4) tick();
    @(negedge clk);
    check(src_hold == '0, "R1", int'(src_hold), 0, "hold in reset");
    check(dst_we == '0, "R1", int'(dst_we), 0, "sink we in reset");
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    check(src_hold == '0 && dst_we == '0, "R1", int'(src_hold), 0, "idle after reset");
    @(posedge clk); #1;

    // R2 / R3: header consumed, payload forwarded
    send_word(0, 32'h1);
    wait_unhold(0, c);
    check(c == 1, "R3", c, 1, "grant latency on free sink");
    send_payload(0, 1, 3);
    repeat (2) tick();
    check(exp_q[1].size() == 0, "R3", exp_q[1].size(), 0, "all payload delivered");

    // R4: busy sink holds the second source
    send_word(1, 32'h1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(src_hold[1] == 1'b1, "R4", int'(src_hold[1]), 1, "hold while sink busy");
      src_we[1] = (k == 1);
      @(posedge clk); #1;
    end
    src_we[1] = 1'b0;

    // R7: done releases the sink to the waiter, source 0 re-arms
    pulse_done(1);
    wait_unhold(1, c);
    check(c == 1, "R7", c, 1, "waiter granted after done");
    send_word(0, 32'h2);
    wait_unhold(0, c);
    check(c == 1, "R7", c, 1, "released source reconnects");

    // R9: two independent streams in parallel
    fork
      send_payload(0, 2, 2);
      send_payload(1, 1, 2);
    join
    repeat (2) tick();
    check(exp_q[1].size() + exp_q[2].size() == 0, "R9",
          exp_q[1].size() + exp_q[2].size(), 0, "parallel streams delivered");
    pulse_done(2);
    pulse_done(1);

    // R5: move sink 3 pointer to 3, then three simultaneous requesters
    send_word(2, 32'h3);
    wait_unhold(2, c);
    pulse_done(3);
    ptr  = 3;
    pend = 4'b1011;
    send_hdr_mask(pend, 8'h3);
    for (int r = 0; r < 3; r++) begin
      automatic int w = rr_pick(ptr, pend);
      c = 0;
      do begin @(negedge clk); c++; end while ((src_hold & pend) == pend && c < 30);
      check(src_hold[w] == 1'b0, "R5", int'(src_hold & pend), int'(pend & ~(4'b1 << w)),
            "round-robin winner");
      check((src_hold & pend) == (pend & ~(4'b1 << w)), "R5", int'(src_hold & pend),
            int'(pend & ~(4'b1 << w)), "losers still held");
      pend = pend & ~(4'b1 << w);
      ptr  = (w + 1) % N;
      @(posedge clk); #1;
      pulse_done(3);
    end

    // R6: full mirrored to hold, burst completes once started
    send_word(0, 32'h0);
    wait_unhold(0, c);
    dst_full[0] = 1'b1;
    @(negedge clk);
    check(src_hold[0] == 1'b1, "R6", int'(src_hold[0]), 1, "hold follows full");
    @(posedge clk); #1;
    dst_full[0] = 1'b0;
    @(negedge clk);
    check(src_hold[0] == 1'b0, "R6", int'(src_hold[0]), 0, "hold drops with full");
    @(posedge clk); #1;
    begin
      automatic logic [31:0] w = $urandom;
      for (int b = 0; b < 4; b++) exp_q[0].push_back(w[8*b +: 8]);
      for (int b = 0; b < 4; b++) begin
        src_we[0] = 1'b1;
        src_data[7:0] = w[8*b +: 8];
        if (b == 2) dst_full[0] = 1'b1;
        tick();
      end
      src_we[0] = 1'b0;
    end
    repeat (2) tick();
    check(exp_q[0].size() == 0, "R6", exp_q[0].size(), 0, "burst completed under full");
    dst_full[0] = 1'b0;
    pulse_done(0);

    // R8: out-of-range address drops bytes, gap re-arms
    ptag = "R8";
    send_word(2, 32'h9);
    send_word(2, $urandom);
    send_word(2, $urandom);
    @(negedge clk);
    check(src_hold[2] == 1'b0, "R8", int'(src_hold[2]), 0, "no hold while dropping");
    @(posedge clk); #1;
    ptag = "R2";
    send_word(2, 32'h0);
    wait_unhold(2, c);
    check(c == 1, "R8", c, 1, "header accepted after gap");
    send_payload(2, 0, 1);
    repeat (2) tick();
    check(exp_q[0].size() == 0, "R8", exp_q[0].size(), 0, "delivery after re-arm");
    pulse_done(0);

    // random traffic
    for (int it = 0; it < 40; it++) begin
      automatic int i = $urandom % N;
      if ($urandom % 5 == 0) begin
        ptag = "R8";
        send_word(i, 32'(M + $urandom % (256 - M)));
        repeat (1 + $urandom % 2) send_word(i, $urandom);
        @(negedge clk);
        check(src_hold[i] == 1'b0, "R8", int'(src_hold[i]), 0, "random drop hold");
        @(posedge clk); #1;
        ptag = "R2";
      end else begin
        automatic int j = $urandom % M;
        send_word(i, 32'(j));
        wait_unhold(i, c);
        check(c < 30, "R4", c, 1, "random grant");
        send_payload(i, j, 1 + $urandom % 3);
        repeat (2) tick();
        check(exp_q[j].size() == 0, "R3", exp_q[j].size(), 0, "random delivery");
        pulse_done(j);
      end
    end

    repeat (3) tick();
    for (int j = 0; j < M; j++)
      check(exp_q[j].size() == 0, "R3", exp_q[j].size(), 0, "final queue empty");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule